// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a 12-bit voltage-output converter that is written over a three-wire serial bus: an active-low select, a serial clock and a data line. The three bus pins are sampled by a much faster system clock. Each pin passes through a two-stage synchronizer, and edges are found by comparing each synchronized sample with the one before it. The bus runs in SPI mode 0: the serial clock idles low and data is taken on its rising edge.

While select is low, every rising serial-clock edge moves one data bit into an input shift register, most significant bit first. When select returns high, the whole shift register is copied into a separate holding register, and the holding register drives the parallel code to the converter in straight binary. Because of this, the converter never sees a half-shifted word. The block also gives a one-cycle update strobe, a one-cycle short-frame flag and a count of bits received in the current frame.

The code output is a level, not a stream. The strobe works as a valid with no ready: the serial bus cannot be stalled, so the block takes no back-pressure, and whatever is downstream must accept each update in the cycle the strobe is high.

Top module: `dac_serial_front`

## Requirements
- R1: While reset is low, and in the first cycle after it is released with select idle high, the code output and the bit count are zero and the strobe and short flag are low.
- R2: After a 12-bit frame, the code equals the received word. The first bit sent lands in bit 11 and the last in bit 0.
- R3: The code does not change while select is low, even after bits have been shifted in. It changes only in the cycle the strobe is high.
- R4: Serial-clock rising edges while select is high shift nothing. The bit count and the code stay unchanged, and a following short frame shows that the shift register was left untouched.
- R5: If more than 12 bits arrive in one frame, the code takes the last 12 bits received.
- R6: If fewer than 12 bits arrive, including none, the shift register is latched exactly as it stands. The short flag is high for one cycle, in the same cycle as the strobe. A frame of 12 or more bits leaves the flag low.
- R7: The strobe is high for exactly one cycle. That cycle begins three system-clock edges after select rises at the pin: two synchronizer stages, then the holding-register load.
- R8: The bit count clears when select falls, goes up by one on each shifted bit, and stays at 31 once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_csn | input | 1 | Serial select, active low, asynchronous to clk |
| bus_sclk | input | 1 | Serial clock, idles low, asynchronous to clk |
| bus_sdi | input | 1 | Serial data, taken on serial-clock rising edge |
| code_o | output | 12 | Straight-binary converter code from the holding register |
| upd_o | output | 1 | One-cycle strobe marking a new code |
| short_o | output | 1 | One-cycle flag: the frame just latched held fewer than 12 bits |
| bits_o | output | 5 | Bits received since select last fell, saturating |

## Verification
Full 12-bit frames use alternating, all-zero, all-one, single-low-bit and single-high-bit words. A bit reversal shows up as a wrong single-bit code, and a stuck or dropped position shows up against the all-one and all-zero words. Overlong frames of 16 and 40 bits tell "last twelve kept" apart from "first twelve kept" and check that the count saturates. A four-bit frame sent after serial-clock toggles with select high shows whether idle edges leaked into the shift register. A zero-bit frame and a mid-frame sample of the code show that the holding register loads only on the select rising edge.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int unsigned BUS_N  = 3;
  localparam int unsigned CSN_I  = 0;
  localparam int unsigned SCLK_I = 1;
  localparam int unsigned SDI_I  = 2;

  typedef struct packed {
    logic csn_lvl;
    logic csn_rise;
    logic csn_fall;
    logic sclk_rise;
    logic sdi_lvl;
  } bus_ev_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int unsigned N = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prv_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= {STAGES{RST_VAL[g]}};
          prev  <= RST_VAL[g];
        end else begin
          chain <= {chain[STAGES-2:0], pin_i[g]};
          prev  <= chain[STAGES-1];
        end
      end
      assign lvl_o[g] = chain[STAGES-1];
      assign prv_o[g] = prev;
    end
  endgenerate
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift
  import dacfe_pkg::*;
#(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_ev_t          ev_i,
  output logic [WIDTH-1:0] sreg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             shift_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIDTH-1:0] sreg;
  logic [CNT_W-1:0] cnt;
  logic             shift_en;

  assign shift_en = ~ev_i.csn_lvl & ev_i.sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (shift_en) begin
      sreg <= {sreg[WIDTH-2:0], ev_i.sdi_lvl};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ev_i.csn_fall) begin
      cnt <= shift_en ? CNT_W'(1) : '0;
    end else if (shift_en && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sreg_o  = sreg;
  assign cnt_o   = cnt;
  assign shift_o = shift_en;
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] sreg_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [WIDTH-1:0] code_o,
  output logic             upd_o,
  output logic             short_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o  <= '0;
      upd_o   <= 1'b0;
      short_o <= 1'b0;
    end else begin
      upd_o   <= load_i;
      short_o <= load_i && (cnt_i < FULL);
      if (load_i) code_o <= sreg_i;
    end
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
#(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_csn,
  input  logic             bus_sclk,
  input  logic             bus_sdi,
  output logic [WIDTH-1:0] code_o,
  output logic             upd_o,
  output logic             short_o,
  output logic [CNT_W-1:0] bits_o
);
  localparam logic [BUS_N-1:0] IDLE = BUS_N'(1) << CSN_I;

  logic [BUS_N-1:0] pins, lvl, prv;
  bus_ev_t          ev;
  logic [WIDTH-1:0] sreg;
  logic             shift_en;
  logic             csn_lvl, csn_fall, csn_rise;

  always_comb begin
    pins         = '0;
    pins[CSN_I]  = bus_csn;
    pins[SCLK_I] = bus_sclk;
    pins[SDI_I]  = bus_sdi;
  end

  dacfe_sync #(.N(BUS_N), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .lvl_o(lvl), .prv_o(prv)
  );

  assign csn_lvl  = lvl[CSN_I];
  assign csn_rise = lvl[CSN_I] & ~prv[CSN_I];
  assign csn_fall = ~lvl[CSN_I] & prv[CSN_I];

  always_comb begin
    ev.csn_lvl   = csn_lvl;
    ev.csn_rise  = csn_rise;
    ev.csn_fall  = csn_fall;
    ev.sclk_rise = lvl[SCLK_I] & ~prv[SCLK_I];
    ev.sdi_lvl   = lvl[SDI_I];
  end

  dacfe_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev_i(ev),
    .sreg_o(sreg), .cnt_o(bits_o), .shift_o(shift_en)
  );

  dacfe_hold #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(csn_rise),
    .sreg_i(sreg), .cnt_i(bits_o),
    .code_o(code_o), .upd_o(upd_o), .short_o(short_o)
  );
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] code_o,
  input logic             upd_o,
  input logic             short_o,
  input logic [CNT_W-1:0] bits_o,
  input logic             csn_lvl,
  input logic             csn_fall,
  input logic             shift_en
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(WIDTH);

  assert_code_only_on_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> upd_o);

  assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  assert_short_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |-> upd_o);

  assert_short_matches_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (short_o == (bits_o < FULL)));

  assert_count_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csn_fall |=> (bits_o <= CNT_W'(1)));

  assert_count_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !csn_fall && bits_o != CNT_MAX) |=> (bits_o == CNT_W'($past(bits_o) + 1'b1)));

  assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csn_lvl |=> $stable(bits_o));
endmodule

bind dac_serial_front dacfe_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_o(code_o), .upd_o(upd_o), .short_o(short_o),
  .bits_o(bits_o), .csn_lvl(csn_lvl), .csn_fall(csn_fall), .shift_en(shift_en)
);

// File: tb/sim_dac_serial_front.sv
module sim_dac_serial_front;
  logic clk = 1'b0;
  logic rst_n, csn, sclk, sdi;
  logic [11:0] code;
  logic upd, shrt;
  logic [4:0] bits;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [11:0] last_code = '0;

  always #2 clk = ~clk;

  dac_serial_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_csn(csn), .bus_sclk(sclk), .bus_sdi(sdi),
    .code_o(code), .upd_o(upd), .short_o(shrt), .bits_o(bits)
  );

  localparam int NV = 7;
  localparam logic [63:0] VD [NV] = '{64'hA5C, 64'h000, 64'hFFF, 64'h001,
                                      64'h800, 64'h555, 64'hBEEF};
  localparam int          VN [NV] = '{12, 12, 12, 12, 12, 12, 16};
  localparam logic [11:0] VE [NV] = '{12'hA5C, 12'h000, 12'hFFF, 12'h001,
                                      12'h800, 12'h555, 12'hEEF};

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    csn = 1'b0;
    wait_n(4);
  endtask

  task automatic send_bits(input logic [63:0] data, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      wait_n(3);
      sclk = 1'b1;
      wait_n(3);
      sclk = 1'b0;
      wait_n(1);
    end
  endtask

  task automatic cs_high_check(input logic [11:0] exp, input bit exp_short,
                               input string req);
    csn = 1'b1;
    wait_n(2);
    check(upd == 1'b0, "R7 strobe early", 32'(upd), 0);
    check(code == last_code, "R3 code before load", 32'(code), 32'(last_code));
    wait_n(1);
    check(upd == 1'b1, "R7 strobe", 32'(upd), 1);
    check(code == exp, req, 32'(code), 32'(exp));
    check(shrt == exp_short, "R6 short flag", 32'(shrt), 32'(exp_short));
    wait_n(1);
    check(upd == 1'b0, "R7 strobe width", 32'(upd), 0);
    check(shrt == 1'b0, "R6 short width", 32'(shrt), 0);
    last_code = exp;
    wait_n(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csn = 1'b1; sclk = 1'b0; sdi = 1'b0;
    wait_n(5);
    // R1 reset state
    check(code == 12'h0, "R1 code", 32'(code), 0);
    check(bits == 5'd0, "R1 bits", 32'(bits), 0);
    check(upd == 1'b0 && shrt == 1'b0, "R1 strobe/short", {upd, shrt}, 0);
    rst_n = 1'b1;
    wait_n(4);
    check(upd == 1'b0 && code == 12'h0, "R1 after release", 32'(upd), 0);

    // R2 / R5: vector table
    for (int i = 0; i < NV; i++) begin
      cs_low();
      check(bits == 5'd0, "R8 clear on select fall", 32'(bits), 0);
      send_bits(VD[i], VN[i]);
      check(bits == 5'(VN[i]), "R8 count", 32'(bits), 32'(VN[i]));
      cs_high_check(VE[i], 1'b0, (VN[i] > 12) ? "R5 last twelve kept" : "R2 word latched");
    end

    // R3: code holds mid-frame
    cs_low();
    send_bits(64'h3C, 6);
    check(code == last_code && upd == 1'b0, "R3 mid-frame hold", 32'(code), 32'(last_code));
    send_bits(64'h0F, 6);
    check(code == last_code, "R3 full shift, select low", 32'(code), 32'(last_code));
    cs_high_check(12'hF0F, 1'b0, "R3 loaded on select rise");

    // R4: idle clock edges ignored
    sdi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_n(3); sclk = 1'b1; wait_n(3); sclk = 1'b0;
    end
    wait_n(3);
    check(bits == 5'd12, "R4 count unchanged", 32'(bits), 12);
    check(code == 12'hF0F && upd == 1'b0, "R4 code unchanged", 32'(code), 32'hF0F);

    // R6: short frame after idle edges
    cs_low();
    send_bits(64'h9, 4);
    cs_high_check(12'h0F9, 1'b1, "R4 R6 short frame latched as is");

    // R6: zero-bit frame
    cs_low();
    check(bits == 5'd0, "R8 clear", 32'(bits), 0);
    cs_high_check(12'h0F9, 1'b1, "R6 empty frame");

    // R8 saturation with R5
    cs_low();
    send_bits(64'h12_3456_789A, 40);
    check(bits == 5'd31, "R8 saturate", 32'(bits), 31);
    cs_high_check(12'h89A, 1'b0, "R5 long frame");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule